// File: doc/BRIEF.md
# Module Clock-Gate Sequencer

This block controls the clock of one peripheral module that sits inside one power domain. Software prepares the change first. It writes a target state, the local-reset level and a force bit into a module control register. If the domain is off, it also sets a power-up request bit. None of these writes has any effect on the module until software writes the command bit that belongs to this block's domain.

Once that command is written, the block raises a busy flag for a fixed number of cycles. Part way through, it turns the domain on if power-up was requested while the domain was off. In the last cycle it commits the target state and the local-reset level. Software polls the busy flag and the status registers until both have settled.

The clock-enable output is high only while the committed state is "enable" and the domain is on. A small register bus with one-cycle strobes gives access to every register. Read data appears on the cycle after the read strobe.

Top module: `modclk_gate_ctl`

## Requirements
- R1: After reset, every register reads zero. The domain is off, the module state is 0, busy is clear, `clk_en` is low and `mod_rst_n` is low (local reset asserted).
- R2: Module control at 0xA00 reads back the bits written to [5:0] (next state), bit 8 (local reset, 0 = in reset) and bit 31 (force). Its other bits read zero. Domain control at 0x300 reads back bit 0 (power-up request), and its other bits read zero.
- R3: A read of any offset other than 0x120, 0x128, 0x200, 0x300, 0x800 and 0xA00 returns zero. The command register 0x120 also reads zero.
- R4: A write to 0x120 with bit DOM_ID set, while the block is not busy, starts a transition. Bit DOM_ID of 0x128 then reads 1 for exactly TRANS_CYCLES consecutive cycles, starting on the cycle after the write, and reads 0 afterwards.
- R5: The state field of module status (0x800 bits [5:0]) keeps its old value while busy. It takes the next state that was latched at the command on the same cycle that busy clears.
- R6: If domain status (0x200 bits [4:0]) is 0 and domain control bit 0 is 1 when the command is written, the domain status becomes 1 DOM_ON_DELAY cycles after the command. Without that request the domain status stays 0.
- R7: `clk_en` and module status bit 12 are 1 exactly when the state is 3 (enable) and the domain is on. State encodings: 0 software-reset-disable, 1 sync-reset, 2 disable, 3 enable.
- R8: Writes to module control or domain control during a transition are stored but do not change the transition in flight. A command written while busy is ignored and does not extend busy.
- R9: `mod_rst_n` takes the value of module control bit 8, as latched at the command, when the transition completes.
- R10: Command bits other than DOM_ID have no effect.
- R11: Read data is valid on the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| clk_en | output | 1 | Gated module clock enable |
| mod_rst_n | output | 1 | Module local reset, active low |

## Verification
The bench builds the block with TRANS_CYCLES = 7, DOM_ON_DELAY = 3 and DOM_ID = 2. The short transition lets a back-to-back read sequence cover every cycle of busy. Within that sequence the bench probes domain status on both sides of the power-up point, and it writes control and a second command while the transition is in flight. Because DOM_ID is not 0, the bench can show that the busy bit sits at position 2, and it can write low command bits that must be ignored.

// File: rtl/modclk_gate_ctl.sv
module modclk_gate_ctl #(
  parameter int TRANS_CYCLES = 8,
  parameter int DOM_ON_DELAY = 4,
  parameter int DOM_ID       = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [11:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        clk_en,
  output logic        mod_rst_n
);
  localparam int CW = $clog2(TRANS_CYCLES + 1);
  localparam logic [11:0] A_CMD = 12'h120, A_TST = 12'h128, A_DST = 12'h200,
                          A_DCTL = 12'h300, A_MST = 12'h800, A_MCTL = 12'h A00;

  logic [5:0]    nxt_q, tgt_q, state_q;
  logic          lrst_q, force_q, dreq_q;
  logic          busy_q, tgt_lrst_q, tgt_pwr_q, dom_on_q, rst_out_q;
  logic [CW-1:0] cnt_q;
  logic [31:0]   rd_mux, rdata_q;

  wire cmd_hit = wr_en && addr == A_CMD && wdata[DOM_ID];
  wire unused_wd = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt_q   <= '0;
      lrst_q  <= 1'b0;
      force_q <= 1'b0;
      dreq_q  <= 1'b0;
    end else if (wr_en) begin
      if (addr == A_MCTL) begin
        nxt_q   <= wdata[5:0];
        lrst_q  <= wdata[8];
        force_q <= wdata[31];
      end
      if (addr == A_DCTL) dreq_q <= wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      tgt_q      <= '0;
      tgt_lrst_q <= 1'b0;
      tgt_pwr_q  <= 1'b0;
      dom_on_q   <= 1'b0;
      state_q    <= '0;
      rst_out_q  <= 1'b0;
    end else if (!busy_q) begin
      if (cmd_hit) begin
        busy_q     <= 1'b1;
        cnt_q      <= '0;
        tgt_q      <= nxt_q;
        tgt_lrst_q <= lrst_q;
        tgt_pwr_q  <= dreq_q && !dom_on_q;
      end
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(DOM_ON_DELAY - 1) && tgt_pwr_q) dom_on_q <= 1'b1;
      if (cnt_q == CW'(TRANS_CYCLES - 1)) begin
        busy_q    <= 1'b0;
        state_q   <= tgt_q;
        rst_out_q <= tgt_lrst_q;
      end
    end
  end

  assign clk_en    = dom_on_q && state_q == 6'd3;
  assign mod_rst_n = rst_out_q;

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_TST:  rd_mux[DOM_ID] = busy_q;
      A_DST:  rd_mux[4:0] = {4'b0, dom_on_q};
      A_DCTL: rd_mux[0] = dreq_q;
      A_MST:  begin rd_mux[5:0] = state_q; rd_mux[12] = clk_en; end
      A_MCTL: begin rd_mux[5:0] = nxt_q; rd_mux[8] = lrst_q; rd_mux[31] = force_q; end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end
  assign rdata = rdata_q;
endmodule

module modclk_gate_ctl_chk #(
  parameter int TRANS_CYCLES = 8,
  parameter int DOM_ID       = 0,
  parameter int CW           = $clog2(TRANS_CYCLES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [11:0]   addr,
  input logic [31:0]   wdata,
  input logic [31:0]   rdata,
  input logic          busy,
  input logic          dom_on,
  input logic [5:0]    state,
  input logic [CW-1:0] cnt
);
  assert_start_on_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en && addr == 12'h120 && wdata[DOM_ID]));
  assert_state_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state != $past(state)) |-> $fell(busy));
  assert_power_in_flight_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dom_on) |-> busy);
  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> cnt == CW'($past(cnt) + 1'b1));
  assert_read_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en && addr == 12'h128) |-> rdata[DOM_ID] == $past(busy));
endmodule

bind modclk_gate_ctl modclk_gate_ctl_chk #(.TRANS_CYCLES(TRANS_CYCLES), .DOM_ID(DOM_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .busy(busy_q), .dom_on(dom_on_q), .state(state_q), .cnt(cnt_q));

// File: tb/tb_modclk_gate_ctl.sv
`timescale 1ns/1ps
module tb_modclk_gate_ctl;
  localparam int T = 7, D = 3, ID = 2;
  localparam logic [31:0] CMD = 32'd1 << ID;
  localparam logic [11:0] A_CMD = 12'h120, A_TST = 12'h128, A_DST = 12'h200,
                          A_DCTL = 12'h300, A_MST = 12'h800, A_MCTL = 12'hA00;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  wire  [31:0] rdata;
  wire clk_en, mod_rst_n;

  modclk_gate_ctl #(.TRANS_CYCLES(T), .DOM_ON_DELAY(D), .DOM_ID(ID)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .clk_en(clk_en), .mod_rst_n(mod_rst_n));

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic rd_seen = 0;

  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) if (rd_seen && exp_q.size() > 0) begin
    logic [31:0] e;
    string t;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    n_chk++;
    if (rdata !== e) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", t, rdata, e);
    end
  end

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pin(input logic got, input logic e, input string t);
    n_chk++;
    if (got !== e) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", t, got, e);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
  endtask

  initial begin
    do_reset();
    // R1 reset state
    pin(clk_en, 0, "R1 clk_en");
    pin(mod_rst_n, 0, "R1 mod_rst_n");
    rd(A_TST, 0, "R1 busy"); rd(A_DST, 0, "R1 domain"); rd(A_MST, 0, "R1 module status");
    rd(A_MCTL, 0, "R1 module control"); rd(A_DCTL, 0, "R1 domain control");
    // R3 unmapped and command reads
    rd(12'h124, 0, "R3 0x124"); rd(12'h004, 0, "R3 0x004"); rd(12'hFFC, 0, "R3 0xFFC");
    // R2 readback
    wr(A_MCTL, 32'hFFFF_FFFF); rd(A_MCTL, 32'h8000_013F, "R2 module control mask");
    wr(A_MCTL, 32'h8000_0103); rd(A_MCTL, 32'h8000_0103, "R2 module control");
    wr(A_DCTL, 32'hFFFF_FFFF); rd(A_DCTL, 32'h1, "R2 domain control");
    wr(A_CMD, CMD); rd(A_CMD, 0, "R3 command reads zero");
    // the command above starts a transition; let it finish
    for (int i = 0; i < T; i++) @(negedge clk);
    do_reset();
    // R10 foreign command bits
    wr(A_MCTL, 32'h8000_0103); wr(A_DCTL, 32'h1);
    wr(A_CMD, ~CMD);
    rd(A_TST, 0, "R10 no busy"); rd(A_DST, 0, "R10 domain untouched");
    rd(A_MST, 0, "R10 state untouched");
    // R4 R6 R8 main transition to enable with power-up
    wr(A_CMD, CMD);
    for (int i = 0; i < D - 1; i++) rd(A_TST, CMD, "R4 busy early");
    rd(A_DST, 0, "R6 before delay");
    rd(A_DST, 1, "R6 after delay");
    rd(A_MST, 0, "R5 state held while busy");
    wr(A_MCTL, 32'h2);
    wr(A_CMD, CMD);
    for (int i = 0; i < T - D - 4; i++) rd(A_TST, CMD, "R4 busy late");
    rd(A_TST, 0, "R8 command while busy ignored");
    rd(A_MST, 32'h1003, "R5 R7 state enable with clock out");
    rd(A_MCTL, 32'h2, "R8 control write stored");
    pin(clk_en, 1, "R7 clk_en high");
    pin(mod_rst_n, 1, "R9 reset released");
    // transition to disable
    wr(A_CMD, CMD);
    for (int i = 0; i < T; i++) rd(A_TST, CMD, "R4 busy length");
    rd(A_TST, 0, "R4 busy clear");
    rd(A_MST, 32'h2, "R5 state disable");
    rd(A_DST, 1, "R6 domain stays on");
    pin(clk_en, 0, "R7 clk_en low in disable");
    pin(mod_rst_n, 0, "R9 local reset applied");
    // enable without domain request
    do_reset();
    wr(A_MCTL, 32'h103);
    wr(A_CMD, CMD);
    for (int i = 0; i < T; i++) rd(A_TST, CMD, "R4 busy no power");
    rd(A_TST, 0, "R4 busy clear no power");
    rd(A_MST, 32'h3, "R7 enable but domain off");
    rd(A_DST, 0, "R6 no request stays off");
    pin(clk_en, 0, "R7 clk_en low domain off");
    pin(mod_rst_n, 1, "R9 reset released");
    @(negedge clk); @(negedge clk);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule